// File: doc/BRIEF.md
# System Control and Exception Gating Unit

This unit keeps the machine-state control bits of a processor core and turns core events into exception requests. It holds a control word, a read-only fault-address register, a page-directory base register and two flags: one that admits the external interrupt line and one that asks for single-step traps. Software reaches the registers through a simple write port and a combinational read port selected by a 3-bit slot number.

Events arrive as one-cycle pulses: instruction retire, floating-point issue, task switch, page fault with its linear address, and commands that clear the task-switched bit and set or clear the interrupt flag. Each cycle the unit picks at most one winner by fixed priority. It then either raises a registered one-cycle exception request with an 8-bit vector, or accepts the interrupt line with a one-cycle acknowledge. The protection-mode and paging enables come straight from the control word.

Top module: `sys_ctrl_gate`

## Requirements
- R1: After synchronous active-low reset, the control word reads 0 except the extension-type bit (bit 4), which equals the strap input. The fault-address, page-directory base and flags slots read 0, and `exc_req`, `exc_vec` and `irq_ack` are 0.
- R2: A software write to slot 0 loads protection-enable (bit 0), math-present (bit 1), emulate (bit 2) and paging (bit 31). `prot_mode` follows bit 0 and `paging_en` follows bit 31.
- R3: While emulate is set, a floating-point issue gives `exc_req`=1 with `exc_vec`=11 in the cycle after the pulse. While emulate is clear, such an issue raises nothing.
- R4: A task-switch pulse sets the task-switched bit (slot 0 bit 3). Software writes to slot 0 neither set nor clear it.
- R5: The clear-task-switched command clears that bit. When it coincides with a task switch, the bit ends up set.
- R6: A page-fault pulse loads its 32-bit address into the fault-address register (slot 2) and raises vector 14 in the next cycle.
- R7: Writes to slot 2 and to the extension-type bit have no effect.
- R8: Slot 3, the page-directory base, stores bits 31:12 of a write. Bits 11:0 read as 0.
- R9: The set and clear commands control the interrupt flag (slot 4 bit 0); clear wins when both arrive together. With the flag set, a high `irq_line` gives `irq_ack`=1 in the next cycle. With the flag clear, the line is ignored.
- R10: While the trap flag (slot 4 bit 1, writable) is set, every retire pulse raises vector 1 in the next cycle, including back-to-back retires.
- R11: Among events in the same cycle, the winner is chosen in this order: page fault, then floating-point with emulate set, then trap, then interrupt. An interrupt that loses gets no acknowledge.
- R12: Slot 1 is reserved: it reads as 0 and ignores writes. Slots 5 to 7 also read 0.
- R13: `exc_req` is high for exactly one cycle per winning event, and `exc_vec` is 0 whenever `exc_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_type_strap | input | 1 | Extension-type value loaded at reset |
| retire_pulse | input | 1 | One instruction retired |
| fp_issue | input | 1 | Floating-point instruction issued |
| task_switch | input | 1 | Task switch performed |
| pf_valid | input | 1 | Page fault detected |
| pf_addr | input | 32 | Faulting linear address |
| clr_ts_cmd | input | 1 | Clear task-switched bit |
| set_if_cmd | input | 1 | Set interrupt flag |
| clr_if_cmd | input | 1 | Clear interrupt flag |
| irq_line | input | 1 | External interrupt line |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_addr | input | 3 | Write slot |
| sw_wdata | input | 32 | Write data |
| sw_rd_addr | input | 3 | Read slot |
| sw_rdata | output | 32 | Read data (combinational) |
| exc_req | output | 1 | Exception request pulse |
| exc_vec | output | 8 | Exception vector |
| irq_ack | output | 1 | Interrupt accepted pulse |
| prot_mode | output | 1 | Protected mode enabled |
| paging_en | output | 1 | Paging enabled |

## Verification
Some rules are checked by assertions on every cycle. A page fault always wins the next request. Any vector raised is 1, 11 or 14, and the vector is 0 when no request is raised. The acknowledge never coincides with a request, and no acknowledge appears while the interrupt flag is clear. The task-switched bit stays set until its clear command, the fault address holds between faults, and the reserved slot reads zero. Other behaviour shows only in the bench's scenarios. These are the full priority ordering among combined events, the gating by the emulate and trap bits, the register field masking, the task-switch and interrupt-flag collision rules, and the values restored by reset.

// File: rtl/sctl_pkg.sv
// Package: shared types and constants for the system control unit.
// Assumes 32-bit registers and an 8-bit exception vector.
package sctl_pkg;
    localparam int unsigned XLEN   = 32;
    localparam int unsigned SLOT_W = 3;
    localparam int unsigned VEC_W  = 8;

    // Control-word bit positions; software and neighbours decode these.
    localparam int unsigned CW_PE = 0;
    localparam int unsigned CW_MP = 1;
    localparam int unsigned CW_EM = 2;
    localparam int unsigned CW_TS = 3;
    localparam int unsigned CW_ET = 4;
    localparam int unsigned CW_PG = 31;

    // Register slots.
    localparam logic [SLOT_W-1:0] SLOT_CTRL  = 3'd0;
    localparam logic [SLOT_W-1:0] SLOT_RSVD  = 3'd1;
    localparam logic [SLOT_W-1:0] SLOT_FAULT = 3'd2;
    localparam logic [SLOT_W-1:0] SLOT_PDIR  = 3'd3;
    localparam logic [SLOT_W-1:0] SLOT_FLAGS = 3'd4;

    // Fixed exception vectors.
    localparam logic [VEC_W-1:0] VEC_STEP  = 8'd1;
    localparam logic [VEC_W-1:0] VEC_NODEV = 8'd11;
    localparam logic [VEC_W-1:0] VEC_PFLT  = 8'd14;

    typedef struct packed {
        logic pg;
        logic et;
        logic ts;
        logic em;
        logic mp;
        logic pe;
    } ctrl_word_t;
endpackage

// File: rtl/sctl_regs.sv
// Module: architectural control registers and software read mux.
// Holds the control word, fault address, page-directory base and flags.
// Assumes single-cycle write strobes and combinational reads.
module sctl_regs
    import sctl_pkg::*;
#(
    parameter int unsigned DW       = XLEN,
    parameter int unsigned AW       = SLOT_W,
    parameter int unsigned PDIR_LSB = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ext_type_strap,
    input  logic          task_switch,
    input  logic          clr_ts_cmd,
    input  logic          pf_valid,
    input  logic [DW-1:0] pf_addr,
    input  logic          set_if_cmd,
    input  logic          clr_if_cmd,
    input  logic          sw_wr_en,
    input  logic [AW-1:0] sw_wr_addr,
    input  logic [DW-1:0] sw_wdata,
    input  logic [AW-1:0] sw_rd_addr,
    output logic [DW-1:0] sw_rdata,
    output ctrl_word_t    cw_o,
    output logic          if_flag,
    output logic          tf_flag
);
    localparam int unsigned PDIR_W = DW - PDIR_LSB;

    ctrl_word_t        cw_q;
    logic [DW-1:0]     fault_q;
    logic [PDIR_W-1:0] pdir_q;
    logic              if_q;
    logic              tf_q;
    logic              wr_ctrl;
    logic              wr_pdir;
    logic              wr_flags;

    // Decode which register a software write targets.
    always_comb begin
        wr_ctrl  = sw_wr_en && (sw_wr_addr == SLOT_CTRL);
        wr_pdir  = sw_wr_en && (sw_wr_addr == SLOT_PDIR);
        wr_flags = sw_wr_en && (sw_wr_addr == SLOT_FLAGS);
    end

    // Software-writable control bits and the hardware-owned task-switched bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cw_q    <= '0;
            cw_q.et <= ext_type_strap;
        end else begin
            if (wr_ctrl) begin
                cw_q.pe <= sw_wdata[CW_PE];
                cw_q.mp <= sw_wdata[CW_MP];
                cw_q.em <= sw_wdata[CW_EM];
                cw_q.pg <= sw_wdata[CW_PG];
            end
            if (task_switch)     cw_q.ts <= 1'b1;
            else if (clr_ts_cmd) cw_q.ts <= 1'b0;
        end
    end

    // Capture the faulting linear address; software cannot write it.
    always_ff @(posedge clk) begin
        if (!rst_n)        fault_q <= '0;
        else if (pf_valid) fault_q <= pf_addr;
    end

    // Page-directory base, aligned: only the upper bits are stored.
    always_ff @(posedge clk) begin
        if (!rst_n)       pdir_q <= '0;
        else if (wr_pdir) pdir_q <= sw_wdata[DW-1:PDIR_LSB];
    end

    // Interrupt flag by command (clear wins); trap flag by software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            if_q <= 1'b0;
            tf_q <= 1'b0;
        end else begin
            if (clr_if_cmd)      if_q <= 1'b0;
            else if (set_if_cmd) if_q <= 1'b1;
            if (wr_flags)        tf_q <= sw_wdata[1];
        end
    end

    // Read mux; reserved and unused slots return zero.
    always_comb begin
        sw_rdata = '0;
        unique case (sw_rd_addr)
            SLOT_CTRL: begin
                sw_rdata[CW_PE] = cw_q.pe;
                sw_rdata[CW_MP] = cw_q.mp;
                sw_rdata[CW_EM] = cw_q.em;
                sw_rdata[CW_TS] = cw_q.ts;
                sw_rdata[CW_ET] = cw_q.et;
                sw_rdata[CW_PG] = cw_q.pg;
            end
            SLOT_FAULT: sw_rdata = fault_q;
            SLOT_PDIR:  sw_rdata = {pdir_q, {PDIR_LSB{1'b0}}};
            SLOT_FLAGS: sw_rdata[1:0] = {tf_q, if_q};
            default:    sw_rdata = '0;
        endcase
    end

    assign cw_o    = cw_q;
    assign if_flag = if_q;
    assign tf_flag = tf_q;

    AST_TS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_q.ts && !clr_ts_cmd) |=> cw_q.ts); // R4
    AST_TS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ts_cmd && !task_switch) |=> !cw_q.ts); // R5
    AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pf_valid |=> $stable(fault_q)); // R7
    AST_ET_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(cw_q.et)); // R7
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_rd_addr == SLOT_RSVD) |-> (sw_rdata == '0)); // R12
endmodule

// File: rtl/sctl_exc_arb.sv
// Module: event-to-exception arbiter.
// Chooses at most one winner per cycle by fixed priority and registers a
// one-cycle request with its vector, or an interrupt acknowledge.
// Assumes gating bits are the register values of the same cycle.
module sctl_exc_arb
    import sctl_pkg::*;
#(
    parameter int unsigned VW = VEC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pf_valid,
    input  logic          fp_issue,
    input  logic          retire_pulse,
    input  logic          irq_line,
    input  logic          em_bit,
    input  logic          tf_flag,
    input  logic          if_flag,
    output logic          exc_req,
    output logic [VW-1:0] exc_vec,
    output logic          irq_ack
);
    logic          win_req;
    logic [VW-1:0] win_vec;
    logic          win_ack;

    // Priority chain: fault, no-device, single-step, then interrupt.
    always_comb begin
        win_req = 1'b1;
        win_vec = '0;
        win_ack = 1'b0;
        if (pf_valid)                   win_vec = VW'(VEC_PFLT);
        else if (fp_issue && em_bit)    win_vec = VW'(VEC_NODEV);
        else if (retire_pulse && tf_flag) win_vec = VW'(VEC_STEP);
        else begin
            win_req = 1'b0;
            win_ack = irq_line && if_flag;
        end
    end

    // Register the winner so outputs are clean one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_req <= 1'b0;
            exc_vec <= '0;
            irq_ack <= 1'b0;
        end else begin
            exc_req <= win_req;
            exc_vec <= win_vec;
            irq_ack <= win_ack;
        end
    end

    AST_PF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |=> (exc_req && exc_vec == VW'(VEC_PFLT))); // R11
    AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> (exc_vec == VW'(VEC_STEP) || exc_vec == VW'(VEC_NODEV)
                     || exc_vec == VW'(VEC_PFLT))); // R13
    AST_IDLE_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_req |-> (exc_vec == '0)); // R13
    AST_ACK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(exc_req && irq_ack)); // R11
    AST_IF_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !if_flag |=> !irq_ack); // R9
endmodule

// File: rtl/sys_ctrl_gate.sv
// Module: top of the system control and exception gating unit.
// Joins the register file and the arbiter; mode enables come from the
// control word. Assumes all event inputs are single-cycle pulses.
module sys_ctrl_gate
    import sctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_type_strap,
    input  logic              retire_pulse,
    input  logic              fp_issue,
    input  logic              task_switch,
    input  logic              pf_valid,
    input  logic [XLEN-1:0]   pf_addr,
    input  logic              clr_ts_cmd,
    input  logic              set_if_cmd,
    input  logic              clr_if_cmd,
    input  logic              irq_line,
    input  logic              sw_wr_en,
    input  logic [SLOT_W-1:0] sw_wr_addr,
    input  logic [XLEN-1:0]   sw_wdata,
    input  logic [SLOT_W-1:0] sw_rd_addr,
    output logic [XLEN-1:0]   sw_rdata,
    output logic              exc_req,
    output logic [VEC_W-1:0]  exc_vec,
    output logic              irq_ack,
    output logic              prot_mode,
    output logic              paging_en
);
    ctrl_word_t cw;
    logic       if_flag;
    logic       tf_flag;

    sctl_regs #(.DW(XLEN), .AW(SLOT_W), .PDIR_LSB(12)) u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .ext_type_strap (ext_type_strap),
        .task_switch    (task_switch),
        .clr_ts_cmd     (clr_ts_cmd),
        .pf_valid       (pf_valid),
        .pf_addr        (pf_addr),
        .set_if_cmd     (set_if_cmd),
        .clr_if_cmd     (clr_if_cmd),
        .sw_wr_en       (sw_wr_en),
        .sw_wr_addr     (sw_wr_addr),
        .sw_wdata       (sw_wdata),
        .sw_rd_addr     (sw_rd_addr),
        .sw_rdata       (sw_rdata),
        .cw_o           (cw),
        .if_flag        (if_flag),
        .tf_flag        (tf_flag)
    );

    sctl_exc_arb #(.VW(VEC_W)) u_arb (
        .clk          (clk),
        .rst_n        (rst_n),
        .pf_valid     (pf_valid),
        .fp_issue     (fp_issue),
        .retire_pulse (retire_pulse),
        .irq_line     (irq_line),
        .em_bit       (cw.em),
        .tf_flag      (tf_flag),
        .if_flag      (if_flag),
        .exc_req      (exc_req),
        .exc_vec      (exc_vec),
        .irq_ack      (irq_ack)
    );

    // Mode enables are direct views of the control word.
    always_comb begin
        prot_mode = cw.pe;
        paging_en = cw.pg;
    end
endmodule

// File: tb/tb_sys_ctrl_gate.sv
module tb_sys_ctrl_gate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_type_strap = 1'b1;
    logic        retire_pulse = 0, fp_issue = 0, task_switch = 0, pf_valid = 0;
    logic [31:0] pf_addr = '0;
    logic        clr_ts_cmd = 0, set_if_cmd = 0, clr_if_cmd = 0, irq_line = 0;
    logic        sw_wr_en = 0;
    logic [2:0]  sw_wr_addr = '0, sw_rd_addr = '0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] sw_rdata;
    logic        exc_req, irq_ack, prot_mode, paging_en;
    logic [7:0]  exc_vec;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk; // 50 MHz

    sys_ctrl_gate dut (.*);

    // Table: [15:12]={pf,fp,retire,irq}, [9]=ack, [8]=req, [7:0]=vec.
    localparam logic [15:0] EVT_TBL [9] = '{
        16'h810E, 16'h410B, 16'h2101, 16'h1200, 16'hF10E,
        16'h710B, 16'h3101, 16'h0000, 16'h910E
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        sw_wr_en = 1; sw_wr_addr = a; sw_wdata = d;
        step();
        sw_wr_en = 0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
        sw_rd_addr = a; #1;
        chk(req, sw_rdata, exp);
    endtask

    task automatic clr_evt();
        retire_pulse = 0; fp_issue = 0; task_switch = 0; pf_valid = 0;
        clr_ts_cmd = 0; set_if_cmd = 0; clr_if_cmd = 0; irq_line = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        // R1 reset state
        chk("R1 exc_req", {31'b0, exc_req}, 0);
        chk("R1 exc_vec", {24'b0, exc_vec}, 0);
        chk("R1 irq_ack", {31'b0, irq_ack}, 0);
        rd_chk("R1 ctrl", 3'd0, 32'h10);
        rd_chk("R1 fault", 3'd2, 0);
        rd_chk("R1 pdir", 3'd3, 0);
        rd_chk("R1 flags", 3'd4, 0);
        rst_n = 1;
        step();

        // R2 mode bits; R4 TS not writable; R7 ET fixed
        wr(3'd0, 32'hFFFF_FFFF);
        rd_chk("R2 ctrl all ones", 3'd0, 32'h8000_0017);
        chk("R2 prot_mode", {31'b0, prot_mode}, 1);
        chk("R2 paging_en", {31'b0, paging_en}, 1);
        wr(3'd0, 32'h0);
        rd_chk("R7 ET kept", 3'd0, 32'h10);
        chk("R2 prot_mode off", {31'b0, prot_mode}, 0);
        chk("R2 paging_en off", {31'b0, paging_en}, 0);

        // R4 / R5 task-switched bit
        task_switch = 1; step(); clr_evt();
        rd_chk("R4 TS set", 3'd0, 32'h18);
        wr(3'd0, 32'h0);
        rd_chk("R4 TS write ignored", 3'd0, 32'h18);
        task_switch = 1; clr_ts_cmd = 1; step(); clr_evt();
        rd_chk("R5 switch wins", 3'd0, 32'h18);
        clr_ts_cmd = 1; step(); clr_evt();
        rd_chk("R5 TS cleared", 3'd0, 32'h10);

        // R12 reserved slot
        wr(3'd1, 32'hFFFF_FFFF);
        rd_chk("R12 reserved", 3'd1, 0);
        rd_chk("R12 unused slot", 3'd6, 0);

        // R8 page-directory base
        wr(3'd3, 32'h1234_5FFF);
        rd_chk("R8 pdir", 3'd3, 32'h1234_5000);

        // R6 page fault; R13 pulse; R7 fault read-only
        pf_addr = 32'hDEAD_BEEF; pf_valid = 1; step(); clr_evt();
        chk("R6 req", {31'b0, exc_req}, 1);
        chk("R6 vec", {24'b0, exc_vec}, 14);
        rd_chk("R6 fault addr", 3'd2, 32'hDEAD_BEEF);
        step();
        chk("R13 req drops", {31'b0, exc_req}, 0);
        chk("R13 vec idle", {24'b0, exc_vec}, 0);
        wr(3'd2, 32'h0);
        rd_chk("R7 fault write ignored", 3'd2, 32'hDEAD_BEEF);

        // Gating off: R3, R10, R9
        fp_issue = 1; step(); clr_evt();
        chk("R3 em clear", {31'b0, exc_req}, 0);
        retire_pulse = 1; step(); clr_evt();
        chk("R10 tf clear", {31'b0, exc_req}, 0);
        irq_line = 1; step(); clr_evt();
        chk("R9 if clear", {31'b0, irq_ack}, 0);

        // R9 flag commands
        set_if_cmd = 1; clr_if_cmd = 1; step(); clr_evt();
        rd_chk("R9 clear wins", 3'd4, 0);
        set_if_cmd = 1; step(); clr_evt();
        rd_chk("R9 if set", 3'd4, 1);
        wr(3'd4, 32'h2);
        rd_chk("R10 tf set", 3'd4, 3);
        wr(3'd0, 32'h4);

        // R11 / R3 / R10 / R9 table of combined events
        for (int i = 0; i < 9; i++) begin
            pf_valid = EVT_TBL[i][15]; fp_issue = EVT_TBL[i][14];
            retire_pulse = EVT_TBL[i][13]; irq_line = EVT_TBL[i][12];
            step(); clr_evt();
            chk($sformatf("R11 row%0d req", i), {31'b0, exc_req}, {31'b0, EVT_TBL[i][8]});
            chk($sformatf("R11 row%0d vec", i), {24'b0, exc_vec}, {24'b0, EVT_TBL[i][7:0]});
            chk($sformatf("R11 row%0d ack", i), {31'b0, irq_ack}, {31'b0, EVT_TBL[i][9]});
        end

        // R10 back-to-back retires
        retire_pulse = 1;
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R10 consecutive req", {31'b0, exc_req}, 1);
            chk("R10 consecutive vec", {24'b0, exc_vec}, 1);
        end
        clr_evt(); step();
        chk("R13 idle after burst", {31'b0, exc_req}, 0);

        // R9 line ignored once cleared
        clr_if_cmd = 1; step(); clr_evt();
        irq_line = 1; step(); clr_evt();
        chk("R9 ignored after clear", {31'b0, irq_ack}, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule